// File: doc/BRIEF.md
# Double-Buffered Receive Endpoint Buffer

This block sits between the packet engine of one USB OUT endpoint and the processor that consumes the received data. It holds two packet buffers. The USB side streams the bytes of each packet in through a write port and closes the packet with an end-of-packet strobe. The byte count of the packet is then latched and the buffer is marked full. The processor reads the buffer that is currently selected one byte at a time. It learns how many bytes are valid from a receive-size output, which reads zero whenever the selected buffer is empty.

When the processor has finished with a buffer, it pulses a read-finish strobe. The strobe releases that buffer, selects the other one and restarts the read pointer. In isochronous mode the start-of-frame pulse performs the same switch, and the read-finish strobe has no effect. The read path is guarded. A read of an empty buffer, or a read past the valid size, returns zero, leaves the pointer where it was and raises a sticky underrun flag. When both buffers are full, arriving packets are refused as a whole and a NAK request is raised for the packet engine.

Top module: `usb_rx_pingpong`

## Requirements
- R1: After reset both buffers are empty: rx_size_o is 0, usb_nak_o is 0, underrun_o is 0 and cpu_data_o is 0.
- R2: Bytes presented with usb_valid_i are stored in arrival order. A usb_eop_i strobe closes the packet: the byte given in the same cycle is included, and an eop given alone closes the packet without adding a byte. The edge that samples usb_eop_i marks the buffer full with its byte count, and rx_size_o shows that count right after that edge if the buffer is the selected one.
- R3: A packet longer than MAX_PKT bytes keeps its first MAX_PKT bytes and drops the rest, and its count is MAX_PKT.
- R4: Each cpu_rd_i pulse on a byte within the valid size puts the next byte of the selected buffer on cpu_data_o after the sampling edge and advances the read pointer by one.
- R5: A cpu_rd_i when the pointer has reached rx_size_o (which includes an empty buffer) makes cpu_data_o 0 and leaves the pointer unchanged. It also sets underrun_o, which stays set until reset.
- R6: In bulk mode (iso_mode_i = 0), rd_done_i while the selected buffer is full releases it and selects the other buffer. rx_size_o then shows the other buffer's count, or 0 if that buffer is empty, and reads start at its first byte. rd_done_i while the selected buffer is empty does nothing, and sof_i does nothing.
- R7: In isochronous mode (iso_mode_i = 1), each sof_i pulse releases the selected buffer and selects the other one, and rd_done_i does nothing. A new packet goes to the unselected buffer when that buffer is empty.
- R8: While both buffers are full, usb_nak_o is 1 and a packet whose first byte arrives is discarded entirely, including bytes that arrive after a buffer is released during that packet. usb_nak_o drops right after the edge at which a buffer is released.
- R9: In bulk mode a new packet goes to the selected buffer if that buffer is empty, and otherwise to the other buffer.
- R10: rx_size_o is 0 whenever the selected buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iso_mode_i | input | 1 | 1 = isochronous (start-of-frame switching), 0 = bulk |
| sof_i | input | 1 | Start-of-frame pulse |
| usb_valid_i | input | 1 | Received byte valid |
| usb_data_i | input | DATA_W | Received byte |
| usb_eop_i | input | 1 | End of packet strobe |
| usb_nak_o | output | 1 | Both buffers full; the packet engine should refuse data |
| cpu_rd_i | input | 1 | Processor byte read strobe |
| cpu_data_o | output | DATA_W | Byte returned by the last read |
| rx_size_o | output | $clog2(MAX_PKT+1) | Valid byte count of the selected buffer |
| rd_done_i | input | 1 | Processor read-finish strobe |
| underrun_o | output | 1 | Sticky flag for a guarded read |

## Verification
A selection register that gets out of step with the write target shows up at once. rx_size_o reads zero while a packet is waiting, or it shows a count after a release that should have emptied the buffer. Both are seen on the cycle after the strobe that caused them. A read pointer that moved on a guarded read is exposed by the first byte of the next packet arriving with an offset. A drop flag that failed to hold is exposed one swap later, when a fragment of a refused packet appears as a nonzero size. The tests therefore place each size and data check directly after the strobe under test, and they drive the mixed-mode and mid-packet release sequences that create these states.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int NBUF = 2;

    // Choose a free buffer for a packet that is starting.
    // Result bit 1: a buffer is free; bit 0: the buffer index.
    function automatic logic [1:0] pick_buf(input logic iso, input logic sel, input logic [NBUF-1:0] full);
        logic pref;
        pref = iso ? ~sel : sel;
        if (!full[pref]) return {1'b1, pref};
        if (!full[~pref]) return {1'b1, ~pref};
        return 2'b00;
    endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic                     wbuf_i,
    input  logic [$clog2(DEPTH)-1:0] waddr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic                     rbuf_i,
    input  logic [$clog2(DEPTH)-1:0] raddr_i,
    output logic [DATA_W-1:0]        rdata_o
);
    import rxf_pkg::*;

    logic [DATA_W-1:0] rd_each [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [DATA_W-1:0] mem_q [DEPTH];
        always_ff @(posedge clk) begin
            if (we_i && (wbuf_i == 1'(b))) mem_q[waddr_i] <= wdata_i;
        end
        assign rd_each[b] = mem_q[raddr_i];
    end

    assign rdata_o = rd_each[rbuf_i];
endmodule

// File: rtl/rxf_fill.sv
module rxf_fill #(
    parameter int DEPTH = 64
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            iso_i,
    input  logic                                            wr_valid_i,
    input  logic                                            eop_i,
    input  logic                                            rd_sel_i,
    input  logic                                            release_i,
    input  logic                                            rel_buf_i,
    output logic                                            we_o,
    output logic                                            wbuf_o,
    output logic [$clog2(DEPTH)-1:0]                        waddr_o,
    output logic [rxf_pkg::NBUF-1:0]                        full_o,
    output logic [rxf_pkg::NBUF-1:0][$clog2(DEPTH+1)-1:0]   cnt_o,
    output logic                                            nak_o
);
    import rxf_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                      active;
        logic                      drop;
        logic                      tgt;
        logic [CW-1:0]             wcnt;
        logic [NBUF-1:0]           full;
        logic [NBUF-1:0][CW-1:0]   cnt;
    } fill_s;

    fill_s q, n;
    logic  start, cur_ok, cur_buf, take;
    logic  [1:0] pick;
    logic  [CW-1:0] wc;

    always_comb begin
        n       = q;
        we_o    = 1'b0;
        waddr_o = q.wcnt[AW-1:0];
        pick    = pick_buf(iso_i, rd_sel_i, q.full);
        start   = !q.active && !q.drop && (wr_valid_i || eop_i);
        cur_ok  = q.active || (start && pick[1]);
        cur_buf = q.active ? q.tgt : pick[0];
        wbuf_o  = cur_buf;
        take    = 1'b0;
        wc      = q.wcnt;

        if (release_i) n.full[rel_buf_i] = 1'b0;

        if (start && !pick[1] && !eop_i) n.drop = 1'b1;
        if (q.drop && eop_i) n.drop = 1'b0;

        if (cur_ok) begin
            take = wr_valid_i && (q.wcnt < CW'(DEPTH));
            we_o = take;
            wc   = q.wcnt + CW'(take);
            if (eop_i) begin
                n.full[cur_buf] = 1'b1;
                n.cnt[cur_buf]  = wc;
                n.active        = 1'b0;
                n.wcnt          = '0;
            end else begin
                n.active = 1'b1;
                n.tgt    = cur_buf;
                n.wcnt   = wc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign full_o = q.full;
    assign cnt_o  = q.cnt;
    assign nak_o  = &q.full;

    // R8: a buffer that holds a packet is never overwritten
    assert_no_write_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> !q.full[wbuf_o]);
    // R8: no byte is stored while the NAK request is up
    assert_nak_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nak_o |-> !we_o);
    // R2: closing an open packet leaves its buffer full unless released in the same cycle
    assert_eop_marks_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_i && q.active && !(release_i && rel_buf_i == q.tgt)) |=> q.full[$past(q.tgt)]);
    for (genvar b = 0; b < NBUF; b++) begin : g_chk
        // R3: a latched count never exceeds one maximum packet
        assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            q.full[b] |-> (q.cnt[b] <= CW'(DEPTH)));
    end
endmodule

// File: rtl/rxf_drain.sv
module rxf_drain #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            iso_i,
    input  logic                                            sof_i,
    input  logic                                            rd_i,
    input  logic                                            done_i,
    input  logic [rxf_pkg::NBUF-1:0]                        full_i,
    input  logic [rxf_pkg::NBUF-1:0][$clog2(DEPTH+1)-1:0]   cnt_i,
    input  logic [DATA_W-1:0]                               rdata_i,
    output logic                                            rbuf_o,
    output logic [$clog2(DEPTH)-1:0]                        raddr_o,
    output logic                                            release_o,
    output logic                                            rel_buf_o,
    output logic [$clog2(DEPTH+1)-1:0]                      size_o,
    output logic [DATA_W-1:0]                               data_o,
    output logic                                            under_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              sel;
        logic [CW-1:0]     ptr;
        logic [DATA_W-1:0] rdata;
        logic              under;
    } drain_s;

    drain_s q, n;
    logic   sel_full, rd_ok, swap;

    always_comb begin
        n        = q;
        sel_full = full_i[q.sel];
        size_o   = sel_full ? cnt_i[q.sel] : '0;
        rd_ok    = rd_i && (q.ptr < size_o);
        raddr_o  = q.ptr[AW-1:0];
        rbuf_o   = q.sel;

        if (rd_i) begin
            if (rd_ok) begin
                n.rdata = rdata_i;
                n.ptr   = q.ptr + CW'(1);
            end else begin
                n.rdata = '0;
                n.under = 1'b1;
            end
        end

        swap = iso_i ? sof_i : (done_i && sel_full);
        if (swap) begin
            n.sel = ~q.sel;
            n.ptr = '0;
        end
        release_o = swap;
        rel_buf_o = q.sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign data_o  = q.rdata;
    assign under_o = q.under;

    // R5: the read pointer never passes the valid size of the selected buffer
    assert_ptr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.ptr <= size_o);
    // R5: a read with nothing left returns zero and flags underrun
    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && size_o == '0) |=> (data_o == '0 && under_o));
    // R5: underrun is sticky
    assert_under_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        under_o |=> under_o);
    // R6: in bulk mode a finish strobe on an empty selection keeps the selection
    assert_bulk_done_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!iso_i && !sel_full) |=> (q.sel == $past(q.sel)));
endmodule

// File: rtl/usb_rx_pingpong.sv
module usb_rx_pingpong #(
    parameter int DATA_W  = 8,
    parameter int MAX_PKT = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         iso_mode_i,
    input  logic                         sof_i,
    input  logic                         usb_valid_i,
    input  logic [DATA_W-1:0]            usb_data_i,
    input  logic                         usb_eop_i,
    output logic                         usb_nak_o,
    input  logic                         cpu_rd_i,
    output logic [DATA_W-1:0]            cpu_data_o,
    output logic [$clog2(MAX_PKT+1)-1:0] rx_size_o,
    input  logic                         rd_done_i,
    output logic                         underrun_o
);
    import rxf_pkg::*;

    localparam int AW = $clog2(MAX_PKT);
    localparam int CW = $clog2(MAX_PKT + 1);

    logic                     we, wbuf, rbuf, rel, rel_buf;
    logic [AW-1:0]            waddr, raddr;
    logic [DATA_W-1:0]        rdata;
    logic [NBUF-1:0]          full;
    logic [NBUF-1:0][CW-1:0]  cnt;

    rxf_fill #(.DEPTH(MAX_PKT)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .iso_i      (iso_mode_i),
        .wr_valid_i (usb_valid_i),
        .eop_i      (usb_eop_i),
        .rd_sel_i   (rbuf),
        .release_i  (rel),
        .rel_buf_i  (rel_buf),
        .we_o       (we),
        .wbuf_o     (wbuf),
        .waddr_o    (waddr),
        .full_o     (full),
        .cnt_o      (cnt),
        .nak_o      (usb_nak_o)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(MAX_PKT)) u_store (
        .clk     (clk),
        .we_i    (we),
        .wbuf_i  (wbuf),
        .waddr_i (waddr),
        .wdata_i (usb_data_i),
        .rbuf_i  (rbuf),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    rxf_drain #(.DATA_W(DATA_W), .DEPTH(MAX_PKT)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .iso_i     (iso_mode_i),
        .sof_i     (sof_i),
        .rd_i      (cpu_rd_i),
        .done_i    (rd_done_i),
        .full_i    (full),
        .cnt_i     (cnt),
        .rdata_i   (rdata),
        .rbuf_o    (rbuf),
        .raddr_o   (raddr),
        .release_o (rel),
        .rel_buf_o (rel_buf),
        .size_o    (rx_size_o),
        .data_o    (cpu_data_o),
        .under_o   (underrun_o)
    );

    // R10: an empty selection always reports a zero size
    assert_size_zero_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !full[rbuf] |-> (rx_size_o == '0));
endmodule

// File: tb/tb_usb_rx_pingpong.sv
module tb_usb_rx_pingpong;
    localparam int DW  = 8;
    localparam int MAX = 64;
    localparam int CW  = $clog2(MAX + 1);

    logic clk = 0, rst_n = 0;
    logic iso = 0, sof = 0, uv = 0, ueop = 0, rd = 0, done = 0;
    logic [DW-1:0] ud = '0;
    logic nak, under;
    logic [DW-1:0] cdata;
    logic [CW-1:0] size;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usb_rx_pingpong #(.DATA_W(DW), .MAX_PKT(MAX)) dut (
        .clk(clk), .rst_n(rst_n), .iso_mode_i(iso), .sof_i(sof),
        .usb_valid_i(uv), .usb_data_i(ud), .usb_eop_i(ueop), .usb_nak_o(nak),
        .cpu_rd_i(rd), .cpu_data_o(cdata), .rx_size_o(size),
        .rd_done_i(done), .underrun_o(under)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; iso = 0; sof = 0; uv = 0; ueop = 0; rd = 0; done = 0; ud = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic send_pkt(int n, int base, bit sep_eop);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            uv = 1; ud = DW'(base + i); ueop = !sep_eop && (i == n - 1);
        end
        if (sep_eop || n == 0) begin
            @(negedge clk);
            uv = 0; ueop = 1;
        end
        @(negedge clk);
        uv = 0; ueop = 0;
    endtask

    task automatic cpu_read(output logic [DW-1:0] v);
        @(negedge clk) rd = 1;
        @(negedge clk) rd = 0;
        v = cdata;
    endtask

    task automatic pulse_done();
        @(negedge clk) done = 1;
        @(negedge clk) done = 0;
    endtask

    task automatic pulse_sof();
        @(negedge clk) sof = 1;
        @(negedge clk) sof = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 size", size, 0);
        chk("R1 nak", nak, 0);
        chk("R1 underrun", under, 0);
        chk("R1 data", cdata, 0);
    endtask

    task automatic t_bulk_basic();
        logic [DW-1:0] v;
        do_reset();
        send_pkt(5, 8'h10, 0);
        chk("R2 R9 size after eop", size, 5);
        for (int i = 0; i < 5; i++) begin
            cpu_read(v);
            chk("R4 byte order", v, 8'h10 + i);
        end
        chk("R4 no underrun yet", under, 0);
        cpu_read(v);
        chk("R5 over-read data", v, 0);
        chk("R5 over-read flag", under, 1);
        pulse_done();
        chk("R6 R10 swap to empty size", size, 0);
        send_pkt(2, 8'h60, 1);
        chk("R2 separate eop count", size, 2);
        chk("R5 underrun sticky", under, 1);
    endtask

    task automatic t_guard_ptr();
        logic [DW-1:0] v;
        do_reset();
        cpu_read(v);
        chk("R5 empty read data", v, 0);
        chk("R5 empty read flag", under, 1);
        send_pkt(3, 8'hA0, 0);
        cpu_read(v);
        chk("R5 pointer unchanged", v, 8'hA0);
    endtask

    task automatic t_pingpong();
        logic [DW-1:0] v;
        do_reset();
        send_pkt(4, 8'h20, 0);
        send_pkt(6, 8'h40, 0);
        chk("R9 first packet selected", size, 4);
        pulse_sof();
        chk("R6 sof ignored in bulk", size, 4);
        pulse_done();
        chk("R6 swap shows other count", size, 6);
        cpu_read(v);
        chk("R6 read restarts", v, 8'h40);
        pulse_done();
        chk("R6 R10 both released", size, 0);
    endtask

    task automatic t_mode_mix();
        do_reset();
        iso = 1;
        send_pkt(3, 8'h30, 0);
        chk("R7 packet to unselected", size, 0);
        @(negedge clk) iso = 0;
        pulse_done();
        chk("R6 done on empty ignored", size, 0);
        pulse_sof();
        chk("R6 sof in bulk ignored", size, 0);
    endtask

    task automatic t_overlong();
        logic [DW-1:0] v;
        do_reset();
        send_pkt(MAX + 3, 0, 0);
        chk("R3 count capped", size, MAX);
        for (int i = 0; i < MAX; i++) cpu_read(v);
        chk("R3 last kept byte", v, MAX - 1);
        cpu_read(v);
        chk("R3 R5 nothing beyond cap", v, 0);
    endtask

    task automatic t_full();
        do_reset();
        send_pkt(3, 8'h01, 0);
        send_pkt(3, 8'h11, 0);
        chk("R8 nak when both full", nak, 1);
        send_pkt(2, 8'h70, 0);
        chk("R8 refused packet keeps size", size, 3);
        // packet starts while full, buffer released mid-packet
        @(negedge clk); uv = 1; ud = 8'h50; ueop = 0;
        @(negedge clk); uv = 0; done = 1;
        @(negedge clk); done = 0;
        chk("R8 nak clears on release", nak, 0);
        uv = 1; ud = 8'h51; ueop = 1;
        @(negedge clk); uv = 0; ueop = 0;
        chk("R8 R6 second buffer visible", size, 3);
        pulse_done();
        chk("R8 tail of refused packet dropped", size, 0);
        send_pkt(2, 8'h77, 0);
        chk("R8 R9 next packet accepted", size, 2);
    endtask

    task automatic t_iso();
        logic [DW-1:0] v;
        do_reset();
        iso = 1;
        send_pkt(4, 8'h80, 0);
        chk("R7 size before sof", size, 0);
        pulse_done();
        chk("R7 done ignored in iso", size, 0);
        pulse_sof();
        chk("R7 sof swap size", size, 4);
        cpu_read(v);
        chk("R7 sof swap data", v, 8'h80);
        send_pkt(2, 8'h90, 0);
        chk("R7 second packet hidden", size, 4);
        pulse_sof();
        chk("R7 second sof size", size, 2);
        cpu_read(v);
        chk("R7 second sof data", v, 8'h90);
    endtask

    initial begin
        t_reset();
        t_bulk_basic();
        t_guard_ptr();
        t_pingpong();
        t_mode_mix();
        t_overlong();
        t_full();
        t_iso();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule